// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block counts pulses of a slow reference tick (nominally 32768 per second) and raises an interrupt flag each time a programmed number of ticks has elapsed. Each reference tick arrives as a one-cycle enable pulse that is already in the system clock domain. Software controls the timer through four byte-wide registers on a simple synchronous bus: control, status, interrupt enable and interrupt flags.

The control register holds an enable bit and a 4-bit interval code. The code selects a power-of-two interval from 4 to 32768 ticks. When an interval completes, the flag is set and the next interval starts at once. Software acknowledges the interrupt by writing a one to the flag bit. Any write to the control register throws away the partial interval in progress. The interrupt request is a level output.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous reset, all four registers read zero, the interval count is zero and `irq` is low.
- R2: Offset 0 (control) and offset 2 (interrupt enable) read back the last byte written to them. `rdata` is zero in any cycle where `rd_en` is low. Reads are combinational, in the same cycle as `rd_en`.
- R3: Offset 1 (status) always reads 0x00, and writes to it change nothing.
- R4: Control bit 0 enables the timer, and control bits 6:3 hold the interval code. With codes 1 to 14 and the enable bit set, the flag goes high on the clock edge that accepts the 2^(code+1)-th tick since the count restarted.
- R5: Codes 0 and 15, or a clear enable bit, never set the flag, however many ticks arrive.
- R6: While the timer stays enabled, intervals repeat back to back with no software action. The next flag comes exactly 2^(code+1) ticks after the previous one.
- R7: Any write to offset 0 resets the count to zero. A tick in the same cycle as that write is not counted.
- R8: The flag is bit 0 of offset 3. Writing a byte with bit 0 set clears the flag; writing a byte with bit 0 clear leaves it unchanged. Bits 7:1 of offset 3 always read zero.
- R9: If an interval completes in the same cycle as a clearing write, the flag ends up set.
- R10: `irq` is high exactly when the flag is set and bit 0 of the interrupt enable register is set.
- R11: Clock cycles without `tick_en` do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse per reference tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the `rd_en` cycle |
| irq | output | 1 | Level interrupt request |

## Verification
A count that is wrong by even one tick appears at `irq` and in the flag register on the first interval boundary. For the shortest code, that is within four ticks of a control write. A restart missed after a control write also shows up within one interval, as an early flag. A wrong priority between set and clear shows as a flag that reads zero right after the completing tick. A wrongly decoded off code shows as a flag that appears where none is expected. Because the bench compares `irq` every cycle, every such fault is caught at the cycle where it first shows.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_IEN  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  logic [7:0]       ctrl_q, ien_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q, last;
  logic [3:0]       code;
  logic             run, ctrl_wr, flag_clr, expire;

  assign code     = ctrl_q[6:3];
  assign run      = ctrl_q[0] && (code != 4'd0) && (code != 4'd15);
  assign last     = (CNT_W'(2) << code) - CNT_W'(1);
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign flag_clr = wr_en && (addr == A_FLAG) && wdata[0];
  assign expire   = run && tick_en && !ctrl_wr && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_wr)                 cnt_q <= '0;
      else if (expire)             cnt_q <= '0;
      else if (run && tick_en)     cnt_q <= cnt_q + CNT_W'(1);

      if (expire)                  flag_q <= 1'b1;
      else if (flag_clr)           flag_q <= 1'b0;

      if (ctrl_wr)                 ctrl_q <= wdata;
      if (wr_en && addr == A_IEN)  ien_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = ctrl_q;
        A_STAT:  rdata = '0;
        A_IEN:   rdata = ien_q;
        A_FLAG:  rdata = {7'd0, flag_q};
        default: rdata = '0;
      endcase
    end
  end

  assign irq = flag_q & ien_q[0];

  // R5
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> cnt_q == '0);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q <= last);

  // R7
  ctrl_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> cnt_q == '0);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !expire) |=> !flag_q);

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ctrl_wr) |=> $stable(cnt_q));

  // R3
  status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT) |-> rdata == 8'd0);

endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en, wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_ctrl, m_ien;
  logic       m_flag;
  int         m_cnt;

  always #10 clk = ~clk;

  pit_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int span_of(input logic [7:0] c);
    int k = int'(c[6:3]);
    if (!c[0] || k == 0 || k == 15) return 0;
    return 1 << (k + 1);
  endfunction

  function automatic logic [7:0] m_read(input logic r, input logic [1:0] a);
    if (!r) return 8'd0;
    case (a)
      2'd0: return m_ctrl;
      2'd2: return m_ien;
      2'd3: return {7'd0, m_flag};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_step(input logic w, input logic [1:0] a, input logic [7:0] d, input logic t);
    int  sp = span_of(m_ctrl);
    bit  ex = 0;
    if (w && a == 2'd0) m_cnt = 0;
    else if (sp != 0 && t) begin
      if (m_cnt == sp - 1) begin m_cnt = 0; ex = 1; end
      else m_cnt++;
    end
    if (ex) m_flag = 1'b1;
    else if (w && a == 2'd3 && d[0]) m_flag = 1'b0;
    if (w && a == 2'd0) m_ctrl = d;
    if (w && a == 2'd2) m_ien = d;
  endtask

  task automatic cyc(input string tag, input logic w, input logic r, input logic [1:0] a,
                     input logic [7:0] d, input logic t);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
    #1;
    if (r) chk({tag, " rdata"}, rdata, m_read(1'b1, a));
    chk({tag, " irq R10"}, {7'd0, irq}, {7'd0, m_flag & m_ien[0]});
    @(posedge clk);
    m_step(w, a, d, t);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick_en = 0;
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, 1'b0, a, d, 1'b0);
  endtask
  task automatic rd(input string tag, input logic [1:0] a);
    cyc(tag, 1'b0, 1'b1, a, 8'd0, 1'b0);
  endtask
  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(tag, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1);
      cyc(tag, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0);
    end
  endtask
  task automatic expect_flag(input string tag, input logic f);
    rd(tag, 2'd3);
    chk({tag, " flag"}, {7'd0, m_flag}, {7'd0, f});
  endtask

  initial begin
    #(20 * 190000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_ctrl = 0; m_ien = 0; m_flag = 0; m_cnt = 0;
    rst = 1; tick_en = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    for (int a = 0; a < 4; a++) rd("R1 reset", 2'(a));
    chk("R2 idle rdata", rdata, 8'd0);

    wr("R2", 2'd0, 8'hB2); rd("R2 ctrl readback", 2'd0);
    wr("R2", 2'd2, 8'hA4); rd("R2 ien readback", 2'd2);
    wr("R3", 2'd1, 8'hFF); rd("R3 status", 2'd1);
    rd("R3 ctrl untouched", 2'd0);
    wr("R2", 2'd2, 8'h01);

    wr("R4", 2'd0, 8'h09);
    ticks("R4", 3); expect_flag("R4 before 4th tick", 1'b0);
    ticks("R4", 1); expect_flag("R4 after 4th tick", 1'b1);
    chk("R10 irq high", {7'd0, irq}, 8'd1);

    wr("R8", 2'd3, 8'hFE); expect_flag("R8 zero write keeps", 1'b1);
    wr("R8", 2'd3, 8'h01); expect_flag("R8 one write clears", 1'b0);

    ticks("R6", 3); expect_flag("R6 early", 1'b0);
    ticks("R6", 1); expect_flag("R6 repeat", 1'b1);
    wr("R8", 2'd3, 8'h01);

    wr("R11", 2'd0, 8'h09);
    ticks("R11", 2);
    repeat (30) cyc("R11 idle", 1'b0, 1'b0, 2'd0, 8'd0, 1'b0);
    ticks("R11", 1); expect_flag("R11 no advance", 1'b0);
    ticks("R11", 1); expect_flag("R11 completes", 1'b1);
    wr("R8", 2'd3, 8'h01);

    wr("R5", 2'd0, 8'h01); ticks("R5 code0", 40); expect_flag("R5 code0", 1'b0);
    wr("R5", 2'd0, 8'h79); ticks("R5 code15", 40); expect_flag("R5 code15", 1'b0);
    wr("R5", 2'd0, 8'h08); ticks("R5 disabled", 40); expect_flag("R5 disabled", 1'b0);

    wr("R7", 2'd0, 8'h09);
    ticks("R7", 3);
    cyc("R7 rewrite with tick", 1'b1, 1'b0, 2'd0, 8'h09, 1'b1);
    ticks("R7", 3); expect_flag("R7 restarted", 1'b0);
    ticks("R7", 1); expect_flag("R7 full interval", 1'b1);

    ticks("R9", 3);
    cyc("R9 clear with expiry", 1'b1, 1'b0, 2'd3, 8'h01, 1'b1);
    expect_flag("R9 set wins", 1'b1);

    wr("R10", 2'd2, 8'h00);
    chk("R10 gated", {7'd0, irq}, 8'd0);
    wr("R10", 2'd2, 8'h01);
    chk("R10 ungated", {7'd0, irq}, 8'd1);
    wr("R8", 2'd3, 8'h01);

    wr("R4", 2'd0, 8'h29);
    ticks("R4 code5", 63); expect_flag("R4 code5 early", 1'b0);
    ticks("R4 code5", 1); expect_flag("R4 code5 done", 1'b1);

    for (int i = 0; i < 6000; i++) begin
      logic       w = ($urandom % 12) == 0;
      logic       r = $urandom % 2;
      logic [1:0] a = 2'($urandom % 4);
      logic [7:0] d = 8'($urandom);
      logic       t = $urandom % 2;
      if (w && a == 2'd0) begin
        int pick = $urandom % 6;
        logic [3:0] c = (pick == 0) ? 4'd0 : (pick == 1) ? 4'd15 : 4'(pick - 1);
        if ($urandom % 4 == 0) a = 2'd3;
        else d = {d[7], c, d[2:1], ($urandom % 5) != 0};
      end
      cyc("R4 R6 R8 R9 random", w, r, a, d, t);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule